// File: doc/BRIEF.md
# Random Word Fill Controller

This block wraps a free-running pseudo-random generator with a small register bank and a word FIFO. Software arms the generator through a register write; from then on the block drops one generator word into the FIFO at a fixed cadence of 256 clock cycles and keeps the FIFO topped up whenever a consumer drains it. Consumers take words through a valid/ready read port.

Before it is armed, the generator still advances on every clock so that its state keeps evolving, but nothing is queued. A reset-control register offers three self-clearing actions: a full soft restart of the sequencing logic, a FIFO flush that keeps the armed state, and clearing of an error flag that records reads attempted on an empty FIFO.

A 64-bit Fibonacci shift register stands in for the entropy source. The cadence counter runs from reset whether or not the block is armed, so the time the block spends waiting before it is armed does not move the later push slots.

Top module: `rng_fill_ctrl`

## Requirements
- R1: After reset the registers at offsets 0x000, 0x010 and 0x018 read zero, `out_valid` is low, `out_data` is zero and `err_flag` is low.
- R2: Until the first write to offset 0x010, no word enters the FIFO and `out_valid` stays low.
- R3: Any write to offset 0x010 arms filling, whatever value is written, and that value reads back unchanged.
- R4: Counting rising edges from reset release (or from the edge that applies a soft reset) as k = 1, 2, ..., a word is pushed only at edges where k is a multiple of 256. The pushed word is the generator state after k-1 steps from the seed 0x0123456789ABCDEF, where one step shifts the state left by one bit and loads bit 0 with the XOR of bits 63, 62, 60 and 59.
- R5: The FIFO holds 16 words and returns them in push order. While it is full no word is pushed and none is lost. After a read frees a slot, pushing resumes at the next multiple of 256.
- R6: The register at offset 0x000 is read/write over all 64 bits and has no effect on timing or data.
- R7: Writing 1 to bit 0 of offset 0x018 applies a soft reset on the following edge: the block is disarmed, the cadence counter restarts, the FIFO is emptied and the generator returns to its seed.
- R8: Writing 1 to bit 1 of offset 0x018 empties the FIFO on the following edge and leaves the block armed, with push slots unchanged.
- R9: Raising `out_ready` while `out_valid` is low sets `err_flag` on the next edge. An empty FIFO presents zero on `out_data`. Writing 1 to bit 2 of offset 0x018 clears `err_flag` on the following edge.
- R10: Bits of offset 0x018 read back as written for one cycle after the write and then clear by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer takes the word shown |
| out_data | output | 64 | Oldest FIFO word, zero when empty |
| err_flag | output | 1 | Read attempted on an empty FIFO |

## Verification
A word pushed at edge k shows up on `out_valid`/`out_data` one edge later, at the falling edge after edge k. The bench keeps its own count of rising edges since reset or soft reset and checks that the first valid falling edge carries the expected k and the generator value after k-1 steps. A register write acts on the edge that samples the strobe. The reset-control actions take effect one edge after that, so flush, soft-reset and error-clear results are sampled two falling edges after the write strobe is driven. The error flag and the read-back values are sampled at the first falling edge after the edge that records them.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam logic [11:0] OFF_MODE = 12'h000;
    localparam logic [11:0] OFF_SIZE = 12'h010;
    localparam logic [11:0] OFF_RSTC = 12'h018;

    localparam int unsigned RC_W      = 3;
    localparam int unsigned RC_SOFT   = 0;
    localparam int unsigned RC_FLUSH  = 1;
    localparam int unsigned RC_ERRCLR = 2;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_SIZE,
        SEL_RSTC
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [11:0] addr);
        case (addr)
            OFF_MODE: return SEL_MODE;
            OFF_SIZE: return SEL_SIZE;
            OFF_RSTC: return SEL_RSTC;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter int unsigned       W     = 64,
    parameter logic [W-1:0]      SEED  = 64'h0123_4567_89AB_CDEF,
    parameter logic [W-1:0]      TAPS  = 64'hD800_0000_0000_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reinit,
    output logic [W-1:0] state
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        if (reinit) begin
            state_d = SEED;
        end else begin
            state_d = {state_q[W-2:0], ^(state_q & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    assert_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop_req,
    input  logic                         flush,
    output logic                         valid_o,
    output logic [W-1:0]                 data_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH):0]       level_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned LVL_W = PTR_W + 1;
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         push_ok, pop_ok;

    assign full_o  = (st_q.lvl == LVL_FULL);
    assign valid_o = (st_q.lvl != '0);
    assign push_ok = push && !full_o && !flush;
    assign pop_ok  = pop_req && valid_o && !flush;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = st_q.wp + 1'b1;
            if (pop_ok)  st_d.rp = st_q.rp + 1'b1;
            st_d.lvl = st_q.lvl + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end

    assign data_o  = valid_o ? mem_q[st_q.rp] : '0;
    assign level_o = st_q.lvl;

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LVL_FULL);

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_req && !flush) |=> full_o);

endmodule

// File: rtl/rng_fill_ctrl.sv
module rng_fill_ctrl
    import rng_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 12,
    parameter int unsigned          DATA_W     = 64,
    parameter int unsigned          FIFO_DEPTH = 16,
    parameter int unsigned          INTERVAL   = 256,
    parameter logic [DATA_W-1:0]    SEED       = 64'h0123_4567_89AB_CDEF,
    parameter logic [DATA_W-1:0]    TAPS       = 64'hD800_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              err_flag
);

    localparam int unsigned       CNT_W    = $clog2(INTERVAL);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(INTERVAL - 1);
    localparam int unsigned       LVL_W    = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        logic              started;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] size;
        logic [RC_W-1:0]   rctl;
        logic              err;
    } ctl_st_t;

    ctl_st_t           st_d, st_q;
    reg_sel_e          sel;
    logic              wr_mode, wr_size, wr_rstc;
    logic              tick, fifo_push, fifo_flush, fifo_full;
    logic [DATA_W-1:0] gen_word;
    logic [LVL_W-1:0]  fifo_level;

    assign sel     = decode_addr(12'(reg_addr));
    assign wr_mode = reg_wr && (sel == SEL_MODE);
    assign wr_size = reg_wr && (sel == SEL_SIZE);
    assign wr_rstc = reg_wr && (sel == SEL_RSTC);

    assign tick       = (st_q.cnt == CNT_LAST);
    assign fifo_flush = st_q.rctl[RC_SOFT] || st_q.rctl[RC_FLUSH];
    assign fifo_push  = st_q.started && tick;

    always_comb begin
        st_d = st_q;
        st_d.cnt  = tick ? '0 : st_q.cnt + 1'b1;
        st_d.rctl = wr_rstc ? reg_wdata[RC_W-1:0] : '0;
        if (wr_mode) st_d.mode = reg_wdata;
        if (wr_size) begin
            st_d.size    = reg_wdata;
            st_d.started = 1'b1;
        end
        if (out_ready && !out_valid) st_d.err = 1'b1;
        if (st_q.rctl[RC_ERRCLR])    st_d.err = 1'b0;
        if (st_q.rctl[RC_SOFT]) begin
            st_d.started = 1'b0;
            st_d.cnt     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE: reg_rdata = st_q.mode;
            SEL_SIZE: reg_rdata = st_q.size;
            SEL_RSTC: reg_rdata = DATA_W'(st_q.rctl);
            default:  reg_rdata = '0;
        endcase
    end

    assign err_flag = st_q.err;

    rng_lfsr #(
        .W    (DATA_W),
        .SEED (SEED),
        .TAPS (TAPS)
    ) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (st_q.rctl[RC_SOFT]),
        .state  (gen_word)
    );

    rng_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (gen_word),
        .pop_req   (out_ready),
        .flush     (fifo_flush),
        .valid_o   (out_valid),
        .data_o    (out_data),
        .full_o    (fifo_full),
        .level_o   (fifo_level)
    );

    assert_idle_no_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.started |=> fifo_level <= $past(fifo_level));

    assert_fill_on_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CNT_LAST) |=> fifo_level <= $past(fifo_level));

    assert_arm_on_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_size && !st_q.rctl[RC_SOFT]) |=> st_q.started);

    assert_full_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !out_ready) |=> fifo_level <= $past(fifo_level));

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rctl[RC_SOFT] |=> (!st_q.started && st_q.cnt == '0 && fifo_level == '0));

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rctl[RC_FLUSH] |=> fifo_level == '0);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rctl[RC_ERRCLR] |=> !err_flag);

    assert_self_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rctl != '0 && !wr_rstc) |=> st_q.rctl == '0);

endmodule

// File: tb/test_rng_fill_ctrl.sv
`timescale 1ns/1ps
module test_rng_fill_ctrl;

    localparam logic [63:0] SEED_V = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] TAPS_V = 64'hD800_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_data;
    logic        err_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int ecnt   = 0;
    int cyc    = 0;
    int base   = 0;

    always #2 clk = ~clk;

    rng_fill_ctrl i_rng_fill_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .err_flag  (err_flag)
    );

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] gen_after(input int n);
        logic [63:0] s = SEED_V;
        for (int i = 0; i < n; i++) s = {s[62:0], ^(s & TAPS_V)};
        return s;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_until(input int k);
        while (ecnt - base < k) @(negedge clk);
    endtask

    task automatic wait_push(output int k);
        k = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (out_valid) begin
                k = ecnt - base;
                break;
            end
        end
    endtask

    task automatic pop_chk(input string req, input logic [63:0] exp);
        chk(req, {63'd0, out_valid}, 64'd1);
        chk(req, out_data, exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        logic [63:0] v;
        int k;
        int bad;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, v); chk("R1 mode", v, 64'd0);
        rd(12'h010, v); chk("R1 size", v, 64'd0);
        rd(12'h018, v); chk("R1 rstc", v, 64'd0);
        chk("R1 valid", {63'd0, out_valid}, 64'd0);
        chk("R1 data", out_data, 64'd0);
        chk("R1 err", {63'd0, err_flag}, 64'd0);

        // R2 nothing queued before arming
        bad = 0;
        while (ecnt < 700) begin
            @(negedge clk);
            if (out_valid) bad++;
        end
        chk("R2 idle pushes", 64'(bad), 64'd0);

        // R3 arm with arbitrary value, R4 first slot and data
        wr(12'h010, 64'hDEAD_BEEF_0000_1234);
        rd(12'h010, v); chk("R3 size readback", v, 64'hDEAD_BEEF_0000_1234);
        wait_push(k);
        chk("R4 first slot", 64'(k), 64'd768);
        chk("R4 first word", out_data, gen_after(767));

        // R5 fill to 16, stall, ordered drain, resume
        wait_until(5220);
        pop_chk("R5 oldest", gen_after(767));
        wait_until(5400);
        for (int m = 4; m <= 18; m++) pop_chk("R5 order", gen_after(256 * m - 1));
        pop_chk("R5 resumed word", gen_after(5375));
        chk("R5 drained", {63'd0, out_valid}, 64'd0);

        // R6 mode register has no effect
        wr(12'h000, '1);
        rd(12'h000, v); chk("R6 mode readback", v, '1);
        wait_push(k);
        chk("R6 slot unchanged", 64'(k), 64'd5632);
        chk("R6 word unchanged", out_data, gen_after(5631));

        // R8 flush keeps armed state
        wait_until(6200);
        wr(12'h018, 64'd2);
        @(negedge clk);
        chk("R8 flushed", {63'd0, out_valid}, 64'd0);
        chk("R8 empty data", out_data, 64'd0);
        wait_push(k);
        chk("R8 still armed slot", 64'(k), 64'd6400);
        chk("R8 word", out_data, gen_after(6399));
        pop_chk("R8 pop", gen_after(6399));

        // R9 error flag on empty read, cleared by bit 2; R10 self clear
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R9 err set", {63'd0, err_flag}, 64'd1);
        chk("R9 empty zero", out_data, 64'd0);
        repeat (3) @(negedge clk);
        chk("R9 err sticky", {63'd0, err_flag}, 64'd1);
        wr(12'h018, 64'd4);
        rd(12'h018, v); chk("R10 bit visible", v, 64'd4);
        @(negedge clk);
        chk("R9 err cleared", {63'd0, err_flag}, 64'd0);
        rd(12'h018, v); chk("R10 bit cleared", v, 64'd0);

        // R7 soft reset
        wait_push(k);
        chk("R7 pre slot", 64'(k), 64'd6656);
        wr(12'h018, 64'd1);
        base = ecnt + 1;
        @(negedge clk);
        chk("R7 fifo emptied", {63'd0, out_valid}, 64'd0);
        bad = 0;
        while (ecnt - base < 700) begin
            @(negedge clk);
            if (out_valid) bad++;
        end
        chk("R7 disarmed", 64'(bad), 64'd0);
        wr(12'h010, 64'd0);
        rd(12'h010, v); chk("R3 zero arms", v, 64'd0);
        wait_push(k);
        chk("R7 slot realigned", 64'(k), 64'd768);
        chk("R7 reseeded word", out_data, gen_after(767));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule